// File: doc/BRIEF.md
# PS/2 Port Controller with Three-Character Collector

This block drives one PS/2 port, for either a keyboard or a mouse. It watches the open-drain clock and data lines. It decodes the frames the device sends and packs up to three received characters into one 32-bit word for the host. Each character has its own valid flag and error flag. A fourth character that arrives before the host reads the word sets an overflow flag and is not stored. The block can stop the device from sending by holding the clock line low once one character, or three characters, are waiting to be read.

In the other direction, the host writes one byte. The block then requests to send by holding the clock low for a set time. After that it pulls data low, shifts the byte out on the device's clock edges and checks that the device acknowledges it. A 16-bit status word shows the following:

- a write-pending bit
- the live levels of both lines
- an idle bit
- two software pull-downs
- the configuration bits
- a no-acknowledge bit
- a timeout bit

The timeout bit is set when a partly received or partly sent frame stalls. It drives an interrupt output when its enable bit is set.

Top module: `ps2_char_port`

## Requirements
- R1: A device frame is 11 bits: a 0 start bit, eight data bits LSB first, an odd parity bit and a 1 stop bit. Each bit is sampled on the falling edge of the clock line after a two-flop synchronizer. The first character after a read lands in `rd_word[23:16]` and sets `rd_word[31]`. A frame whose start bit samples as 1 is ignored.
- R2: The second character lands in `rd_word[15:8]` with valid bit 30, and the third lands in `rd_word[7:0]` with valid bit 29. A valid bit is only set when the valid bits of all earlier slots are set.
- R3: Error bits 26, 25 and 24 belong to the first, second and third slots. An error bit is set when that character's parity is not odd or its stop bit samples as 0.
- R4: A character that arrives while three slots are full sets `rd_word[28]` (overflow) and leaves the three stored slots unchanged.
- R5: `rd_word[27]` equals the `IS_MOUSE` parameter: 0 for a keyboard port, 1 for a mouse port.
- R6: While `rd_strobe` is high, `rd_word` shows the collected contents. On the following cycle, all valid bits, error bits, data bits and the overflow bit are 0.
- R7: The control bits are `ctl_wdata[3]` (stop after one character) and `ctl_wdata[4]` (stop after three). With the bit set, `clk_drive_low` is high while at least one character, or all three characters, are held. A read releases the clock.
- R8: A pulse on `tx_wr` while the block is idle starts a send. The block holds the clock low for `INHIBIT_CYC` cycles, then releases it and pulls data low. On each later device falling edge it presents data bits LSB first, then odd parity, then a released stop bit. On the 11th falling edge it samples the acknowledge. `status[10]` is 1 when the data line was high at that edge. Received frames are ignored during a send.
- R9: `status[0]` is write-pending. `status[1]` and `status[2]` are the synchronized clock and data levels. `status[3]` and `status[4]` are the software pull-downs set by `ctl_wdata[0]` and `ctl_wdata[1]`; they force `clk_drive_low` and `data_drive_low` high. `status[5]` is idle (neither receiving nor sending).
- R10: The timeout bit is `status[6]`. It is set when a frame is partly received, or is being shifted out, and no falling clock edge is seen for `TIMEOUT_CYC` cycles. The partial frame is discarded. Writing `ctl_wdata[5]`=1 clears the bit. `ctl_wdata[2]` is the timeout enable and shows in `status[7]`.
- R11: `irq` is high when both the timeout bit and its enable bit are set. `status[8]` and `status[9]` read back the two clamp enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | Level of the PS/2 clock line |
| ps2_data_in | input | 1 | Level of the PS/2 data line |
| clk_drive_low | output | 1 | Enables the open-drain pull-down on the clock line |
| data_drive_low | output | 1 | Enables the open-drain pull-down on the data line |
| rd_strobe | input | 1 | Host read of the collected word; clears it |
| rd_word | output | 32 | Collected characters, flags and port identity |
| tx_wr | input | 1 | Starts a host-to-device send |
| tx_byte | input | 8 | Byte to send |
| ctl_wr | input | 1 | Control register write |
| ctl_wdata | input | 8 | Control value: pulls, timeout enable, clamps, timeout clear |
| status | output | 16 | Status word |
| irq | output | 1 | Timeout interrupt |

## Verification
- **Received characters:** a character reaches `rd_word` about four cycles after the falling clock edge of its stop bit (two synchronizer flops, the edge flop and the receiver register). The bench device waits tens of cycles after each frame before any read.
- **Read clear:** a read is checked in the same cycle as the strobe. The cleared word is due one cycle later. A released clamp is checked two cycles after the strobe.
- **Line levels:** status line levels follow a pin change after two cycles, and the bench samples them five cycles later.
- **Host send:** the device model counts the inhibit cycles and samples each data bit after its own rising edge.
- **Timeout:** the timeout is checked a margin of 50 cycles after the `TIMEOUT_CYC` window has elapsed.

// File: rtl/ps2_port_pkg.sv
package ps2_port_pkg;
  localparam int CHAR_W = 8;
  localparam int SLOTS  = 3;
  localparam int FRAME_BITS = CHAR_W + 3;

  typedef struct packed {
    logic              valid;
    logic              err;
    logic [CHAR_W-1:0] data;
  } slot_t;

  // bit that makes the total count of ones odd
  function automatic logic odd_par(input logic [CHAR_W-1:0] b);
    return ~(^b);
  endfunction

  function automatic logic [31:0] pack_word(input slot_t s0, input slot_t s1,
                                            input slot_t s2, input logic ovf,
                                            input logic id);
    return {s0.valid, s1.valid, s2.valid, ovf, id, s0.err, s1.err, s2.err,
            s0.data, s1.data, s2.data};
  endfunction
endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl  = s2;
  assign fall = s3 & ~s2;
endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              abort,
  input  logic              fall,
  input  logic              dat,
  output logic              busy,
  output logic              char_v,
  output logic [CHAR_W-1:0] char_d,
  output logic              char_e
);
  localparam int IW = $clog2(FRAME_BITS + 1);
  localparam logic [IW-1:0] PAR_IDX  = IW'(CHAR_W + 1);
  localparam logic [IW-1:0] STOP_IDX = IW'(CHAR_W + 2);

  logic [IW-1:0]     idx;
  logic [CHAR_W-1:0] sr;
  logic              par;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      sr     <= '0;
      par    <= 1'b0;
      char_v <= 1'b0;
      char_d <= '0;
      char_e <= 1'b0;
    end else begin
      char_v <= 1'b0;
      if (abort || !en) begin
        idx <= '0;
      end else if (fall) begin
        if (idx == '0) begin
          if (!dat) idx <= IW'(1);
        end else if (idx == PAR_IDX) begin
          par <= dat;
          idx <= idx + 1'b1;
        end else if (idx == STOP_IDX) begin
          char_v <= 1'b1;
          char_d <= sr;
          char_e <= (par != odd_par(sr)) || !dat;
          idx    <= '0;
        end else begin
          sr  <= {dat, sr[CHAR_W-1:1]};
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign busy = (idx != '0);
endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2_port_pkg::*;
#(
  parameter int INHIBIT_CYC = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              abort,
  input  logic              fall,
  input  logic              dat,
  output logic              busy,
  output logic              shifting,
  output logic              clk_low,
  output logic              data_low,
  output logic              nack
);
  localparam int CW = $clog2(INHIBIT_CYC + 1);
  localparam int FW = CHAR_W + 2;
  localparam int IW = $clog2(FW + 1);

  typedef enum logic [1:0] {TX_IDLE, TX_INHIB, TX_SHIFT} tx_st_e;

  tx_st_e        st;
  logic [CW-1:0] cnt;
  logic [FW-1:0] sr;
  logic [IW-1:0] idx;
  logic          txbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= TX_IDLE;
      cnt   <= '0;
      sr    <= '0;
      idx   <= '0;
      txbit <= 1'b1;
      nack  <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: if (start) begin
          st    <= TX_INHIB;
          cnt   <= '0;
          sr    <= {1'b1, odd_par(tx_data), tx_data};
          txbit <= 1'b0;
          idx   <= '0;
        end
        TX_INHIB: begin
          if (cnt == CW'(INHIBIT_CYC - 1)) st <= TX_SHIFT;
          else cnt <= cnt + 1'b1;
        end
        TX_SHIFT: begin
          if (abort) begin
            st <= TX_IDLE;
          end else if (fall) begin
            if (idx == IW'(FW)) begin
              nack <= dat;
              st   <= TX_IDLE;
            end else begin
              txbit <= sr[0];
              sr    <= sr >> 1;
              idx   <= idx + 1'b1;
            end
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign busy     = (st != TX_IDLE);
  assign shifting = (st == TX_SHIFT);
  assign clk_low  = (st == TX_INHIB);
  assign data_low = shifting && !txbit;
endmodule

// File: rtl/ps2_char_collector.sv
module ps2_char_collector
  import ps2_port_pkg::*;
#(
  parameter bit IS_MOUSE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_v,
  input  logic [CHAR_W-1:0] char_d,
  input  logic              char_e,
  input  logic              rd,
  input  logic              clamp_one,
  input  logic              clamp_three,
  output logic [31:0]       word,
  output logic              hold
);
  localparam int NW = $clog2(SLOTS + 1);

  slot_t         slots [SLOTS];
  logic          ovf;
  logic [NW-1:0] cnt, base;

  // a read empties the word before a same-cycle character is stored
  assign base = rd ? '0 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
      ovf <= 1'b0;
      cnt <= '0;
    end else begin
      if (rd) begin
        for (int i = 0; i < SLOTS; i++) slots[i] <= '0;
        ovf <= 1'b0;
      end
      cnt <= base;
      if (char_v) begin
        if (base < NW'(SLOTS)) begin
          slots[base] <= '{valid: 1'b1, err: char_e, data: char_d};
          cnt         <= base + 1'b1;
        end else begin
          ovf <= 1'b1;
        end
      end
    end
  end

  assign word = pack_word(slots[0], slots[1], slots[2], ovf, IS_MOUSE);
  assign hold = (clamp_one && cnt != '0) || (clamp_three && cnt == NW'(SLOTS));
endmodule

// File: rtl/ps2_char_port.sv
module ps2_char_port
  import ps2_port_pkg::*;
#(
  parameter bit IS_MOUSE    = 1'b1,
  parameter int INHIBIT_CYC = 200,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ps2_clk_in,
  input  logic        ps2_data_in,
  output logic        clk_drive_low,
  output logic        data_drive_low,
  input  logic        rd_strobe,
  output logic [31:0] rd_word,
  input  logic        tx_wr,
  input  logic [7:0]  tx_byte,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_wdata,
  output logic [15:0] status,
  output logic        irq
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  logic [1:0] lvl, fall;
  logic clk_lvl, dat_lvl, clk_fall;
  logic rx_busy, char_evt, rx_err;
  logic [CHAR_W-1:0] rx_data;
  logic tx_busy, tx_shifting, tx_clk_low, tx_data_low, tx_nack;
  logic wr_pend, hold, idle;
  logic sw_pull_clk, sw_pull_data, to_en, clamp_one_q, clamp_three_q, timeout_q;
  logic [TW-1:0] tcnt;
  logic wdt_active, wdt_fire;

  ps2_line_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin({ps2_data_in, ps2_clk_in}),
    .lvl(lvl), .fall(fall)
  );
  assign clk_lvl  = lvl[0];
  assign dat_lvl  = lvl[1];
  assign clk_fall = fall[0];

  ps2_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(!tx_busy), .abort(wdt_fire),
    .fall(clk_fall), .dat(dat_lvl), .busy(rx_busy),
    .char_v(char_evt), .char_d(rx_data), .char_e(rx_err)
  );

  ps2_host_tx #(.INHIBIT_CYC(INHIBIT_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_wr), .tx_data(tx_byte),
    .abort(wdt_fire), .fall(clk_fall), .dat(dat_lvl),
    .busy(tx_busy), .shifting(tx_shifting), .clk_low(tx_clk_low),
    .data_low(tx_data_low), .nack(tx_nack)
  );

  ps2_char_collector #(.IS_MOUSE(IS_MOUSE)) u_col (
    .clk(clk), .rst_n(rst_n), .char_v(char_evt), .char_d(rx_data),
    .char_e(rx_err), .rd(rd_strobe), .clamp_one(clamp_one_q),
    .clamp_three(clamp_three_q), .word(rd_word), .hold(hold)
  );

  // stall watchdog shared by both directions
  assign wdt_active = rx_busy || tx_shifting;
  assign wdt_fire   = wdt_active && (tcnt == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt          <= '0;
      timeout_q     <= 1'b0;
      sw_pull_clk   <= 1'b0;
      sw_pull_data  <= 1'b0;
      to_en         <= 1'b0;
      clamp_one_q   <= 1'b0;
      clamp_three_q <= 1'b0;
    end else begin
      if (!wdt_active || clk_fall || wdt_fire) tcnt <= '0;
      else tcnt <= tcnt + 1'b1;
      if (ctl_wr) begin
        sw_pull_clk   <= ctl_wdata[0];
        sw_pull_data  <= ctl_wdata[1];
        to_en         <= ctl_wdata[2];
        clamp_one_q   <= ctl_wdata[3];
        clamp_three_q <= ctl_wdata[4];
      end
      if (wdt_fire) timeout_q <= 1'b1;
      else if (ctl_wr && ctl_wdata[5]) timeout_q <= 1'b0;
    end
  end

  assign wr_pend        = tx_busy;
  assign idle           = !rx_busy && !tx_busy;
  assign clk_drive_low  = tx_clk_low || sw_pull_clk || hold;
  assign data_drive_low = tx_data_low || sw_pull_data;
  assign irq            = timeout_q && to_en;
  assign status = {5'b0, tx_nack, clamp_three_q, clamp_one_q, to_en, timeout_q,
                   idle, sw_pull_data, sw_pull_clk, dat_lvl, clk_lvl, wr_pend};
endmodule

// File: rtl/ps2_char_port_chk.sv
module ps2_char_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_strobe,
  input logic        char_evt,
  input logic [31:0] rd_word,
  input logic        clamp_one_q,
  input logic        clk_drive_low,
  input logic        wr_pend,
  input logic        tx_wr
);
  // R2
  slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word[29] |-> rd_word[30]) and (rd_word[30] |-> rd_word[31]));

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[28] |-> (rd_word[31:29] == 3'b111));

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !char_evt) |=> (rd_word[31:28] == 4'b0 && rd_word[26:0] == 27'b0));

  // R7
  clamp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_one_q && rd_word[31]) |-> clk_drive_low);

  // R8
  wr_pend_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_pend) |-> $past(tx_wr));
endmodule

bind ps2_char_port ps2_char_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .char_evt(char_evt),
  .rd_word(rd_word), .clamp_one_q(clamp_one_q), .clk_drive_low(clk_drive_low),
  .wr_pend(wr_pend), .tx_wr(tx_wr)
);

// File: tb/sim_ps2_char_port.sv
`timescale 1ns/1ps
module sim_ps2_char_port;
  localparam int INH = 200;
  localparam int TMO = 1000;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic dev_clk_low = 1'b0, dev_data_low = 1'b0;
  logic rd_strobe = 1'b0, tx_wr = 1'b0, ctl_wr = 1'b0;
  logic [7:0] tx_byte = 8'h00, ctl_wdata = 8'h00;
  logic clk_drive_low, data_drive_low, irq;
  logic [31:0] rd_word;
  logic [15:0] status;
  logic clk_line, data_line;

  assign clk_line  = ~(dev_clk_low | clk_drive_low);
  assign data_line = ~(dev_data_low | data_drive_low);

  ps2_char_port #(.IS_MOUSE(1'b1), .INHIBIT_CYC(INH), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(clk_line), .ps2_data_in(data_line),
    .clk_drive_low(clk_drive_low), .data_drive_low(data_drive_low),
    .rd_strobe(rd_strobe), .rd_word(rd_word), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .status(status), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [7:0] m_d[3];
  logic m_e[3];
  int m_n = 0;
  logic m_ovf = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = 32'h0;
    w[27] = 1'b1;
    w[28] = m_ovf;
    for (int i = 0; i < m_n; i++) begin
      w[31-i] = 1'b1;
      w[26-i] = m_e[i];
      w[23-8*i -: 8] = m_d[i];
    end
    return w;
  endfunction

  // device-to-host frame; nbits < 11 leaves a partial frame
  task automatic dev_send(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                          input int nbits);
    logic [10:0] f;
    f = {~bad_stop, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      dev_data_low = ~f[i];
      cyc(HALF / 2);
      dev_clk_low = 1'b1;
      cyc(HALF);
      dev_clk_low = 1'b0;
      cyc(HALF / 2);
    end
    dev_data_low = 1'b0;
    cyc(HALF);
    if (nbits == 11) begin
      if (m_n < 3) begin
        m_d[m_n] = b;
        m_e[m_n] = bad_par | bad_stop;
        m_n++;
      end else m_ovf = 1'b1;
    end
  endtask

  // driver: expected word goes to the scoreboard queue
  task automatic read_word(input string tag);
    exp_q.push_back(model_word());
    tag_q.push_back(tag);
    rd_strobe = 1'b1;
    cyc(1);
    rd_strobe = 1'b0;
    m_n = 0;
    m_ovf = 1'b0;
    chk({tag, " cleared"}, rd_word, 32'h0800_0000);
    cyc(1);
  endtask

  // monitor: compares while the strobe is high
  always @(negedge clk) begin
    if (rd_strobe && rst_n) begin
      if (exp_q.size() == 0) chk("R6 unexpected read", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), rd_word, exp_q.pop_front());
    end
  end

  task automatic ctl_write(input logic [7:0] v);
    ctl_wdata = v;
    ctl_wr = 1'b1;
    cyc(1);
    ctl_wr = 1'b0;
  endtask

  task automatic dev_receive(output logic [9:0] bits, output int inh);
    inh = 0;
    wait (clk_drive_low === 1'b1);
    while (clk_drive_low === 1'b1) begin
      @(posedge clk);
      inh++;
    end
    #1;
    wait (data_drive_low === 1'b1);
    cyc(HALF / 2);
    for (int i = 0; i < 10; i++) begin
      dev_clk_low = 1'b1;
      cyc(HALF);
      dev_clk_low = 1'b0;
      cyc(1);
      bits[i] = data_line;
      cyc(HALF / 2);
    end
    dev_data_low = 1'b1;
    cyc(HALF / 2);
    dev_clk_low = 1'b1;
    cyc(HALF);
    dev_clk_low = 1'b0;
    cyc(HALF / 2);
    dev_data_low = 1'b0;
    cyc(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [9:0] rbits;
    int inh;
    cyc(4);
    rst_n = 1'b1;
    cyc(4);
    // R5 R9 reset state
    chk("R5 reset word", rd_word, 32'h0800_0000);
    chk("R9 reset status", {16'h0, status}, 32'h0000_0026);
    chk("R11 reset irq", {31'h0, irq}, 32'h0);

    // R1 single character
    dev_send(8'hA5, 0, 0, 11);
    read_word("R1 one char");

    // R2 R3 three characters, parity error in slot 2, stop error in slot 3
    dev_send(8'h12, 0, 0, 11);
    dev_send(8'h34, 1, 0, 11);
    dev_send(8'hFE, 0, 1, 11);
    read_word("R2 R3 three chars");

    // R4 overflow on a fourth character
    dev_send(8'h01, 0, 0, 11);
    dev_send(8'h80, 0, 0, 11);
    dev_send(8'h7F, 1, 0, 11);
    dev_send(8'hC3, 0, 0, 11);
    read_word("R4 overflow");

    // R7 stop after one character
    ctl_write(8'h08);
    dev_send(8'h55, 0, 0, 11);
    chk("R7 clamp after one", {31'h0, clk_drive_low}, 32'h1);
    chk("R11 clamp one readback", {31'h0, status[8]}, 32'h1);
    read_word("R6 clamped read");
    chk("R7 release after read", {31'h0, clk_drive_low}, 32'h0);

    // R7 stop after three characters
    ctl_write(8'h10);
    dev_send(8'h11, 0, 0, 11);
    dev_send(8'h22, 0, 0, 11);
    chk("R7 no clamp at two", {31'h0, clk_drive_low}, 32'h0);
    dev_send(8'h33, 0, 0, 11);
    chk("R7 clamp at three", {31'h0, clk_drive_low}, 32'h1);
    read_word("R7 three read");
    chk("R7 release three", {31'h0, clk_drive_low}, 32'h0);
    ctl_write(8'h00);

    // R1 a start bit of 1 is ignored
    dev_data_low = 1'b0;
    dev_clk_low = 1'b1; cyc(HALF); dev_clk_low = 1'b0; cyc(HALF);
    chk("R1 bad start ignored", rd_word, 32'h0800_0000);
    chk("R9 idle after bad start", {31'h0, status[5]}, 32'h1);

    // R9 software pulls
    ctl_write(8'h01);
    cyc(5);
    chk("R9 pull clock", {15'h0, clk_drive_low, status}, {15'h0, 1'b1, 16'h002C});
    ctl_write(8'h02);
    cyc(5);
    chk("R9 pull data", {15'h0, data_drive_low, status}, {15'h0, 1'b1, 16'h0032});
    ctl_write(8'h00);
    cyc(5);

    // R8 host send
    fork
      dev_receive(rbits, inh);
      begin
        tx_byte = 8'h3C;
        tx_wr = 1'b1;
        cyc(1);
        tx_wr = 1'b0;
        cyc(5);
        chk("R8 write pending", {31'h0, status[0]}, 32'h1);
      end
    join
    chk("R8 inhibit length", (inh >= INH) ? 32'h1 : 32'h0, 32'h1);
    chk("R8 sent bits", {22'h0, rbits}, {22'h0, 1'b1, ~^8'h3C, 8'h3C});
    chk("R8 ack and idle", {16'h0, status}, 32'h0000_0026);
    chk("R8 no char from send", rd_word, 32'h0800_0000);

    // R10 R11 timeout on a partial frame
    ctl_write(8'h04);
    dev_send(8'h00, 0, 0, 4);
    cyc(TMO + 50);
    chk("R10 timeout status", {16'h0, status}, 32'h0000_00E6);
    chk("R11 irq set", {31'h0, irq}, 32'h1);
    ctl_write(8'h24);
    cyc(1);
    chk("R10 timeout cleared", {15'h0, irq, status}, {15'h0, 1'b0, 16'h00A6});
    dev_send(8'h5A, 0, 0, 11);
    read_word("R10 partial discarded");

    cyc(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule